// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received bytes from an on-chip receive FIFO and writes them into a ring of host buffers. Each buffer has the same fixed size, and each has a descriptor with a status word. The descriptors fill in ring order. When a frame is longer than one buffer, it continues into the next descriptors. After the last byte of a buffer has been written, the block writes that descriptor's status word. The descriptor-done bit in that word passes ownership of the descriptor to software.

Software gives descriptors back by moving a tail pointer forward. The block's head pointer shows the next descriptor it will claim. The block never stalls the link. When no descriptor is free, it discards the incoming data and increments an overrun counter.

The input stream is valid/ready. After reset, `s_ready` stays high, so every beat presented with `s_valid` is taken on that clock edge. The block applies no back-pressure. Each beat carries one byte, and `s_last` marks the final byte of a frame.

Top module: `rxdw_ring_writer`

## Requirements
- R1: `s_ready` is low while `rst_n` is low. From the first clock edge after reset is released, `s_ready` stays high, and every beat with `s_valid` high is accepted.
- R2: An accepted byte that is stored drives `buf_we` high in the same cycle. `buf_wdata` carries the byte, and `buf_addr` is `{descriptor index, byte offset}`, with offsets counting up from 0 inside each buffer.
- R3: A buffer closes on its `BUF_BYTES`-th byte or on a byte marked last, whichever comes first. Each closed buffer moves `head` forward by exactly one (modulo the ring size). `st_idx` names the descriptor just closed.
- R4: Exactly one cycle after a buffer's final byte is written, `st_we` pulses with the status word. Bit 0 (done) is 1, and bits 31:16 hold the number of bytes stored in that buffer.
- R5: Bit 1 (end of packet) of the status word is set only on the descriptor holding the frame's final byte. Earlier descriptors of a spanning frame have bit 1 clear.
- R6: The descriptor at `head` is written only when `head+1 != sw_tail` (modulo the ring size). A descriptor beyond that point is never written.
- R7: A frame whose first byte arrives while `head+1 == sw_tail` is dropped whole: there are no buffer or status writes for it, and `overruns` increases by one.
- R8: Suppose a buffer fills in the middle of a frame while the following descriptor is not usable. That descriptor's status gets bit 2 (error) and bit 1 set, the rest of the frame is discarded, and `overruns` increases by one.
- R9: During reset, `head` and `overruns` are 0 and there are no writes.
- R10: After software advances `sw_tail`, the returned descriptors are used again. The next frames are stored starting at the current `head`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted (high after reset) |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Final byte of a frame |
| sw_tail | input | IDX_W | Ring tail pointer, advanced by software |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | IDX_W+log2(BUF_BYTES) | Buffer byte address {index, offset} |
| buf_wdata | output | 8 | Buffer byte data |
| st_we | output | 1 | Descriptor status write strobe |
| st_idx | output | IDX_W | Descriptor index of the status write |
| st_word | output | 32 | Status word: done b0, end b1, error b2, length b31:16 |
| head | output | IDX_W | Next descriptor the block will claim |
| overruns | output | CNT_W | Count of dropped or truncated frames |

## Verification
The assertions assume that `sw_tail` only ever moves forward and never passes `head`. Under that assumption, free space can only grow while a frame is arriving, so the mid-frame descriptor check stays consistent. They also assume that `BUF_BYTES` is a power of two that fits in the 16-bit length field. The stimulus changes `sw_tail` only between frames, always in the forward direction, and it never returns a descriptor the block has not yet closed. Frames are sent both back to back and with idle gaps. Frame lengths include a partial buffer, an exactly full buffer, a frame spanning three descriptors, a frame truncated at a buffer boundary, and a frame refused outright.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int ST_DONE_BIT = 0;
  localparam int ST_EOP_BIT  = 1;
  localparam int ST_ERR_BIT  = 2;

  function automatic logic [31:0] pack_status(logic [15:0] len, logic eop, logic err);
    return {len, 13'd0, err, eop, 1'b1};
  endfunction
endpackage

// File: rtl/rxdw_ring_ctl.sv
module rxdw_ring_ctl #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] head,
  output logic             can_cur,
  output logic             can_next
);
  logic [IDX_W-1:0] head_q;
  logic [IDX_W-1:0] h1, h2;

  assign h1       = head_q + IDX_W'(1);
  assign h2       = head_q + IDX_W'(2);
  assign can_cur  = (h1 != tail);
  assign can_next = (h2 != tail);
  assign head     = head_q;

  always_ff @(posedge clk) begin
    if (!rst_n) head_q <= '0;
    else if (adv) head_q <= h1;
  end

  // R3: head never jumps by more than one descriptor per cycle
  p_head_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q == $past(head_q)) || (head_q == $past(head_q) + IDX_W'(1)));
endmodule

// File: rtl/rxdw_frame_fill.sv
module rxdw_frame_fill
  import rxdw_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int BUF_BYTES = 512,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [7:0]        data,
  input  logic              last,
  input  logic [IDX_W-1:0]  head,
  input  logic              can_cur,
  input  logic              can_next,
  output logic              adv,
  output logic              ovr_inc,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [31:0]       st_word
);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(BUF_BYTES - 1);

  logic [OFF_W-1:0] off_q, off_n;
  logic             drop_q, drop_n;
  logic             close, trunc;
  logic [15:0]      fill_len;

  assign fill_len  = 16'({1'b0, off_q} + (OFF_W+1)'(1));
  assign buf_addr  = {head, off_q};
  assign buf_wdata = data;

  always_comb begin
    buf_we  = 1'b0;
    adv     = 1'b0;
    close   = 1'b0;
    trunc   = 1'b0;
    ovr_inc = 1'b0;
    off_n   = off_q;
    drop_n  = drop_q;
    if (beat) begin
      if (drop_q) begin
        if (last) drop_n = 1'b0;
      end else if (off_q == '0 && !can_cur) begin
        ovr_inc = 1'b1;
        drop_n  = !last;
      end else begin
        buf_we = 1'b1;
        close  = last || (off_q == OFF_MAX);
        if (close) begin
          adv   = 1'b1;
          off_n = '0;
          trunc = !last && !can_next;
          if (trunc) begin
            drop_n  = 1'b1;
            ovr_inc = 1'b1;
          end
        end else begin
          off_n = off_q + OFF_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q   <= '0;
      drop_q  <= 1'b0;
      st_we   <= 1'b0;
      st_idx  <= '0;
      st_word <= '0;
    end else begin
      off_q  <= off_n;
      drop_q <= drop_n;
      st_we  <= close;
      if (close) begin
        st_idx  <= head;
        st_word <= pack_status(fill_len, last | trunc, trunc);
      end
    end
  end

  // R4: a status write always follows a committed buffer byte
  p_status_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> $past(buf_we));
  // R4: the length field lies within one buffer
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_we |-> (st_word[31:16] != 16'd0 && st_word[31:16] <= 16'(BUF_BYTES)));
  // R5: a clean close marks end of packet exactly when the final byte was last
  p_eop_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_word[ST_ERR_BIT]) |-> (st_word[ST_EOP_BIT] == $past(last)));
endmodule

// File: rtl/rxdw_ovr_count.sv
module rxdw_ovr_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

  // R7: the counter steps by at most one per cycle
  p_ovr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rxdw_ring_writer.sv
module rxdw_ring_writer #(
  parameter int IDX_W     = 3,
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 16,
  localparam int OFF_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic [IDX_W-1:0]  sw_tail,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [31:0]       st_word,
  output logic [IDX_W-1:0]  head,
  output logic [CNT_W-1:0]  overruns
);
  logic rdy_q, beat, adv, can_cur, can_next, ovr_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else rdy_q <= 1'b1;
  end
  assign s_ready = rdy_q;
  assign beat    = s_valid & rdy_q;

  rxdw_ring_ctl #(.IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(adv), .tail(sw_tail),
    .head(head), .can_cur(can_cur), .can_next(can_next)
  );

  rxdw_frame_fill #(.IDX_W(IDX_W), .BUF_BYTES(BUF_BYTES)) u_fill (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(s_data), .last(s_last),
    .head(head), .can_cur(can_cur), .can_next(can_next),
    .adv(adv), .ovr_inc(ovr_inc),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word)
  );

  rxdw_ovr_count #(.CNT_W(CNT_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .inc(ovr_inc), .count(overruns)
  );

  // R1: once out of reset the input is always ready
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> s_ready);
  // R6: no buffer write into a descriptor the ring does not own
  p_no_write_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_addr[ADDR_W-1:OFF_W] + IDX_W'(1) != sw_tail));
  // R7: no byte is written without an accepted input beat
  p_write_needs_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (s_valid && s_ready));
endmodule

// File: tb/tb_rxdw_ring_writer.sv
`timescale 1ns/1ps
module tb_rxdw_ring_writer;
  localparam int IW  = 2;
  localparam int D   = 4;
  localparam int BUF = 16;
  localparam int OW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [IW-1:0] sw_tail = '0;
  logic s_ready, buf_we, st_we;
  logic [IW+OW-1:0] buf_addr;
  logic [7:0] buf_wdata;
  logic [IW-1:0] st_idx, head;
  logic [31:0] st_word;
  logic [15:0] overruns;

  always #2.5 clk = ~clk;

  rxdw_ring_writer #(.IDX_W(IW), .BUF_BYTES(BUF), .CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .sw_tail(sw_tail),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .st_we(st_we), .st_idx(st_idx), .st_word(st_word),
    .head(head), .overruns(overruns)
  );

  int n_tests = 0, n_fail = 0;
  int m_head = 0, m_off = 0, m_drop = 0, m_ovr = 0;
  int m_st_we = 0, m_st_idx = 0;
  logic [31:0] m_st_word = '0;
  logic [31:0] st_img [D];
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic l);
    int e_we, e_addr, n_head, n_off, n_drop, n_ovr, n_st_we;
    logic [31:0] n_word;
    bit trunc;
    @(negedge clk);
    s_valid = v; s_data = d; s_last = l;
    #1;
    chk("R1 ready", 32'(s_ready), 32'd1);
    chk("R3 head", 32'(head), 32'(m_head));
    chk("R7 R8 overruns", 32'(overruns), 32'(m_ovr));
    chk("R4 st_we", 32'(st_we), 32'(m_st_we));
    if (m_st_we != 0) begin
      chk("R3 st_idx", 32'(st_idx), 32'(m_st_idx));
      chk("R4 R5 R8 st_word", st_word, m_st_word);
    end
    if (st_we) st_img[st_idx] = st_word;
    e_we = 0; e_addr = 0; n_head = m_head; n_off = m_off; n_drop = m_drop;
    n_ovr = m_ovr; n_st_we = 0; n_word = '0;
    if (v) begin
      if (m_drop != 0) begin
        if (l) n_drop = 0;
      end else if (m_off == 0 && ((m_head + 1) % D) == int'(sw_tail)) begin
        n_ovr = m_ovr + 1;
        n_drop = l ? 0 : 1;
      end else begin
        e_we = 1;
        e_addr = m_head * BUF + m_off;
        if (l || m_off == BUF - 1) begin
          trunc = !l && (((m_head + 2) % D) == int'(sw_tail));
          n_st_we = 1;
          n_word = {16'(m_off + 1), 13'd0, trunc, l | trunc, 1'b1};
          n_head = (m_head + 1) % D;
          n_off = 0;
          if (trunc) begin n_drop = 1; n_ovr = m_ovr + 1; end
        end else n_off = m_off + 1;
      end
    end
    chk("R2 buf_we", 32'(buf_we), 32'(e_we));
    if (e_we != 0) begin
      chk("R2 buf_addr", 32'(buf_addr), 32'(e_addr));
      chk("R2 buf_wdata", 32'(buf_wdata), 32'(d));
    end
    if (buf_we)
      chk("R6 owned", 32'(((int'(buf_addr) / BUF + 1) % D) != int'(sw_tail)), 32'd1);
    if (n_st_we != 0) m_st_idx = m_head;
    m_head = n_head; m_off = n_off; m_drop = n_drop; m_ovr = n_ovr;
    m_st_we = n_st_we; m_st_word = n_word;
    @(posedge clk);
  endtask

  task automatic send(input int len, input int base, input bit gaps);
    for (int i = 0; i < len; i++) begin
      step(1'b1, 8'(base + i), i == len - 1);
      if (gaps && (i % 3 == 1)) step(1'b0, 8'hxx, 1'b0);
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) st_img[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 head in reset", 32'(head), 32'd0);
    chk("R9 overruns in reset", 32'(overruns), 32'd0);
    chk("R9 no buffer write", 32'(buf_we), 32'd0);
    chk("R9 no status write", 32'(st_we), 32'd0);
    chk("R1 not ready in reset", 32'(s_ready), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);

    send(5, 8'h10, 1'b0);             // partial buffer
    send(16, 8'h40, 1'b1);            // exactly one buffer, with gaps
    send(20, 8'h80, 1'b0);            // truncated at boundary
    send(7, 8'hc0, 1'b0);             // refused whole
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R5 short frame status", st_img[0], 32'h0005_0003);
    chk("R3 full buffer status", st_img[1], 32'h0010_0003);
    chk("R8 truncated status", st_img[2], 32'h0010_0007);
    chk("R7 two overruns", 32'(overruns), 32'd2);

    sw_tail = 2'd3;                   // software returns 0,1,2
    send(40, 8'h20, 1'b0);            // spans three descriptors
    step(1'b0, 8'h00, 1'b0);
    chk("R5 first span no end", st_img[3], 32'h0010_0001);
    chk("R5 middle span no end", st_img[0], 32'h0010_0001);
    chk("R10 reuse tail span", st_img[1], 32'h0008_0003);

    sw_tail = 2'd1;                   // returns 3,0
    send(3, 8'h55, 1'b1);
    send(1, 8'h99, 1'b0);
    send(4, 8'h11, 1'b0);             // refused again
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    chk("R10 back to back", st_img[2], 32'h0003_0003);
    chk("R4 single byte", st_img[3], 32'h0001_0003);
    chk("R7 third overrun", 32'(overruns), 32'd3);
    chk("R3 head wrapped", 32'(head), 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule